// File: doc/BRIEF.md
# Secure Memory Region Filter

This block sits between the request side of a memory path and the memory controller. It checks every read or write request and either forwards it or blocks it. To decide, it finds the address region that covers the request and compares the request's security state and direction with that region's four permission bits.

There is one background region, index 0, which always spans the whole address space. There are also `NREG` numbered regions. Each numbered region has an inclusive base and top address and an enable bit. Where enabled regions overlap, the highest index wins. A blocked request is never forwarded. It returns an error, and a blocked read returns all-zero data.

Region settings are loaded through a small register port. That port accepts writes only from secure callers.

Top module: `secure_region_filter`

## Requirements
- R1: After reset, every numbered region is disabled and region 0 grants secure read and secure write only, so a non-secure read anywhere is blocked and a secure write anywhere passes.
- R2: An enabled numbered region matches an address when base <= address <= top, with both ends inclusive. A disabled region never matches.
- R3: An address matched by no enabled numbered region uses the permissions of region 0.
- R4: When several enabled regions match, the one with the highest index decides.
- R5: The request is non-secure when `req_prot_i[1]` is 1 and secure when it is 0. Bits 0 and 2 of `req_prot_i` have no effect on the decision.
- R6: The attribute word of a region has these bits: bit 0 enable, bit 1 secure read, bit 2 secure write, bit 3 non-secure read, bit 4 non-secure write. A request passes only if the bit for its security state and direction is set. With `req_valid_i` low, neither `mem_valid_o` nor `resp_err_o` is asserted.
- R7: A blocked read is not forwarded. It raises `resp_err_o` and returns zero on `resp_rdata_o`. A permitted read returns `mem_rdata_i` with no error.
- R8: A blocked write does not raise `mem_valid_o` and raises `resp_err_o`. A permitted write is forwarded with its address and data.
- R9: A configuration write with `cfg_prot_i[1]`=1 (non-secure) changes no region setting.
- R10: A configuration write takes effect from the next clock edge. A request in the same cycle is judged with the settings from before the write.
- R11: `cfg_sel_i` selects the field written: 0 base, 1 top, 2 attribute. Region 0 keeps its full-range coverage and ignores its enable bit. Its four permission bits are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_prot_i | input | 3 | Protection field of the configuration write; bit 1 = non-secure |
| cfg_idx_i | input | IW | Region index written |
| cfg_sel_i | input | 2 | Field select: 0 base, 1 top, 2 attribute |
| cfg_wdata_i | input | AW | Configuration write data |
| req_valid_i | input | 1 | Request valid |
| req_we_i | input | 1 | Request is a write |
| req_prot_i | input | 3 | Request protection field; bit 1 = non-secure |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Request write data |
| mem_valid_o | output | 1 | Forwarded request valid |
| mem_we_o | output | 1 | Forwarded request is a write |
| mem_addr_o | output | AW | Forwarded address |
| mem_wdata_o | output | DW | Forwarded write data |
| mem_rdata_i | input | DW | Read data from memory controller |
| resp_err_o | output | 1 | Request blocked |
| resp_rdata_o | output | DW | Read data returned to requester |

## Verification
A region reprogram and a request that hits the same region can arrive in the same cycle. The bench provokes this by driving a secure attribute write, which opens region 6 to non-secure access, together with a non-secure read inside region 6. Before the clock edge the bench expects the read to be blocked under the old attribute. Just after the edge, with the request still held, it expects the same read to pass.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef struct packed {
    logic ns_wr;
    logic ns_rd;
    logic s_wr;
    logic s_rd;
    logic en;
  } attr_t;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_TOP  = 2'd1,
    SEL_ATTR = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/srf_region_regs.sv
module srf_region_regs
  import srf_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [2:0]              cfg_prot_i,
  input  logic [IW-1:0]           cfg_idx_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic [AW-1:0]           cfg_wdata_i,
  output logic [NREG:0][AW-1:0]   base_o,
  output logic [NREG:0][AW-1:0]   top_o,
  output attr_t [NREG:0]          attr_o
);
  logic wr_ok;
  logic unused_prot;
  assign wr_ok       = cfg_we_i & ~cfg_prot_i[1];
  assign unused_prot = cfg_prot_i[2] ^ cfg_prot_i[0];

  for (genvar r = 0; r <= NREG; r++) begin : g_reg
    logic hit;
    assign hit = wr_ok && (cfg_idx_i == IW'(r));
    if (r == 0) begin : g_bg
      // background: fixed full range, always enabled, perms writable
      logic [3:0] perm_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) perm_q <= 4'b0011;
        else if (hit && cfg_sel_i == SEL_ATTR) perm_q <= cfg_wdata_i[4:1];
      end
      assign base_o[r] = '0;
      assign top_o[r]  = '1;
      assign attr_o[r] = attr_t'({perm_q, 1'b1});
    end else begin : g_num
      logic [AW-1:0] base_q, top_q;
      attr_t         attr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q <= '0;
          top_q  <= '0;
          attr_q <= '0;
        end else if (hit) begin
          case (cfg_sel_i)
            SEL_BASE: base_q <= cfg_wdata_i;
            SEL_TOP:  top_q  <= cfg_wdata_i;
            SEL_ATTR: attr_q <= attr_t'(cfg_wdata_i[4:0]);
            default:  ;
          endcase
        end
      end
      assign base_o[r] = base_q;
      assign top_o[r]  = top_q;
      assign attr_o[r] = attr_q;
    end
  end
endmodule

// File: rtl/srf_region_select.sv
module srf_region_select
  import srf_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]         addr_i,
  input  logic [NREG:0][AW-1:0] base_i,
  input  logic [NREG:0][AW-1:0] top_i,
  input  attr_t [NREG:0]        attr_i,
  output attr_t                 attr_o
);
  logic [NREG:1] hit;

  for (genvar r = 1; r <= NREG; r++) begin : g_hit
    assign hit[r] = attr_i[r].en && (addr_i >= base_i[r]) && (addr_i <= top_i[r]);
  end

  // ascending scan: highest matching index overrides
  always_comb begin
    attr_o = attr_i[0];
    for (int r = 1; r <= NREG; r++) begin
      if (hit[r]) attr_o = attr_i[r];
    end
  end

  logic unused_bg;
  assign unused_bg = ^{base_i[0], top_i[0]};
endmodule

// File: rtl/srf_perm_check.sv
module srf_perm_check
  import srf_pkg::*;
(
  input  attr_t attr_i,
  input  logic  we_i,
  input  logic  nonsec_i,
  output logic  allow_o
);
  always_comb begin
    unique case ({nonsec_i, we_i})
      2'b00:   allow_o = attr_i.s_rd;
      2'b01:   allow_o = attr_i.s_wr;
      2'b10:   allow_o = attr_i.ns_rd;
      default: allow_o = attr_i.ns_wr;
    endcase
  end

  logic unused_en;
  assign unused_en = attr_i.en;
endmodule

// File: rtl/secure_region_filter.sv
module secure_region_filter
  import srf_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_prot_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic [2:0]    req_prot_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          resp_err_o,
  output logic [DW-1:0] resp_rdata_o
);
  logic [NREG:0][AW-1:0] base, top;
  attr_t [NREG:0]        attr;
  attr_t                 sel_attr;
  logic                  allow;

  srf_region_regs #(.NREG(NREG), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_prot_i, .cfg_idx_i, .cfg_sel_i, .cfg_wdata_i,
    .base_o(base), .top_o(top), .attr_o(attr)
  );

  srf_region_select #(.NREG(NREG), .AW(AW)) u_sel (
    .addr_i(req_addr_i), .base_i(base), .top_i(top), .attr_i(attr), .attr_o(sel_attr)
  );

  srf_perm_check u_perm (
    .attr_i(sel_attr), .we_i(req_we_i), .nonsec_i(req_prot_i[1]), .allow_o(allow)
  );

  assign mem_valid_o  = req_valid_i & allow;
  assign mem_we_o     = req_we_i;
  assign mem_addr_o   = req_addr_i;
  assign mem_wdata_o  = req_wdata_i;
  assign resp_err_o   = req_valid_i & ~allow;
  assign resp_rdata_o = (req_valid_i && allow && !req_we_i) ? mem_rdata_i : '0;

  logic unused_prot;
  assign unused_prot = req_prot_i[2] ^ req_prot_i[0];
endmodule

// File: rtl/srf_checker.sv
module srf_checker
  import srf_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_we_i,
  input logic [2:0]     cfg_prot_i,
  input logic           req_valid_i,
  input logic           req_we_i,
  input logic           mem_valid_o,
  input logic           resp_err_o,
  input logic [DW-1:0]  resp_rdata_o,
  input attr_t [NREG:0] attr_i
);
  // R7
  blk_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_err_o && !req_we_i) |-> resp_rdata_o == '0);
  // R8
  pass_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && resp_err_o));
  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!mem_valid_o && !resp_err_o));
  // R6
  valid_decided_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({mem_valid_o, resp_err_o}) == 1);
  // R9
  ns_cfg_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_prot_i[1]) |=> $stable(attr_i));
  // R11
  bg_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_i[0].en);
endmodule

bind secure_region_filter srf_checker #(.NREG(NREG), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .cfg_we_i, .cfg_prot_i, .req_valid_i, .req_we_i,
  .mem_valid_o, .resp_err_o, .resp_rdata_o, .attr_i(attr)
);

// File: tb/tb_secure_region_filter.sv
`timescale 1ns/1ps
module tb_secure_region_filter;
  localparam int NREG = 8;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int IW   = $clog2(NREG + 1);
  localparam logic [DW-1:0] RD = 32'hA5C3_0F96;
  localparam logic [2:0] P_S  = 3'b000;
  localparam logic [2:0] P_NS = 3'b010;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic          cfg_we = 0;
  logic [2:0]    cfg_prot = 0;
  logic [IW-1:0] cfg_idx = 0;
  logic [1:0]    cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic          req_valid = 0, req_we = 0;
  logic [2:0]    req_prot = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic          mem_valid, mem_we, resp_err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, resp_rdata;

  secure_region_filter #(.NREG(NREG), .AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_prot_i(cfg_prot), .cfg_idx_i(cfg_idx),
    .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_prot_i(req_prot),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(RD),
    .resp_err_o(resp_err), .resp_rdata_o(resp_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] addr;
    logic        we;
    logic [2:0]  prot;
    logic        pass;
    logic [3:0]  req;
  } vec_t;

  // region1 0x1000-0x1FFF all perms; region2 0x1800-0x18FF s_rd only;
  // region3 0x4000-0x4FFF ns_rd only; region5 0x8000-0x8FFF disabled
  localparam vec_t VEC [16] = '{
    '{32'h0000_1000, 1'b0, P_NS,   1'b1, 4'd2},  // R2 base inclusive
    '{32'h0000_1FFF, 1'b1, P_NS,   1'b1, 4'd2},  // R2 top inclusive
    '{32'h0000_0FFF, 1'b0, P_NS,   1'b0, 4'd3},  // R3 below region1
    '{32'h0000_2000, 1'b0, P_S,    1'b1, 4'd3},  // R3 bg secure read
    '{32'h0000_1800, 1'b0, P_S,    1'b1, 4'd4},  // R4 region2 wins
    '{32'h0000_1800, 1'b0, P_NS,   1'b0, 4'd4},  // R4 region2 blocks ns
    '{32'h0000_18FF, 1'b1, P_S,    1'b0, 4'd8},  // R8 region2 no s_wr
    '{32'h0000_1900, 1'b1, P_NS,   1'b1, 4'd8},  // R8 back in region1
    '{32'h0000_4000, 1'b0, P_NS,   1'b1, 4'd6},  // R6 ns_rd set
    '{32'h0000_4000, 1'b0, P_S,    1'b0, 4'd6},  // R6 s_rd clear
    '{32'h0000_4FFF, 1'b1, P_NS,   1'b0, 4'd6},  // R6 ns_wr clear
    '{32'h0000_8000, 1'b0, P_NS,   1'b0, 4'd2},  // R2 disabled region5
    '{32'h0000_8000, 1'b1, P_S,    1'b1, 4'd3},  // R3 bg secure write
    '{32'h0000_2000, 1'b0, 3'b101, 1'b1, 4'd5},  // R5 bits 0,2 ignored
    '{32'h0000_2000, 1'b0, 3'b111, 1'b0, 4'd5},  // R5 bit1 non-secure
    '{32'h0000_5000, 1'b0, P_NS,   1'b0, 4'd7}   // R7 blocked read zero
  };

  task automatic check(input string req, input logic [DW+1:0] act, input logic [DW+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input int idx, input logic [1:0] sel, input logic [AW-1:0] d,
                        input logic [2:0] prot);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_sel = sel; cfg_wdata = d; cfg_prot = prot;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic region(input int idx, input logic [AW-1:0] b, input logic [AW-1:0] t,
                        input logic [4:0] a);
    cfg_wr(idx, 2'd0, b, P_S);
    cfg_wr(idx, 2'd1, t, P_S);
    cfg_wr(idx, 2'd2, AW'(a), P_S);
  endtask

  function automatic logic [DW+1:0] expect_of(input logic pass, input logic we);
    return {pass, ~pass, (pass && !we) ? RD : '0};
  endfunction

  // drive at negedge, sample 5 ns later (combinational path)
  task automatic req_chk(input string tag, input logic [AW-1:0] a, input logic we,
                         input logic [2:0] prot, input logic pass);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_we = we; req_prot = prot; req_wdata = ~a;
    #5;
    check(tag, {mem_valid, resp_err, resp_rdata}, expect_of(pass, we));
    if (pass && we)
      check(tag, {2'b00, mem_addr ^ mem_wdata}, {2'b00, 32'hFFFF_FFFF});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk); #5;
    check("R1 idle", {mem_valid, resp_err, resp_rdata}, '0);
    req_chk("R1 ns read", 32'h0000_0100, 1'b0, P_NS, 1'b0);
    req_chk("R1 s write", 32'hFFFF_FFFF, 1'b1, P_S, 1'b1);
    req_chk("R1 s read", 32'h0000_8000, 1'b0, P_S, 1'b1);
    req_valid = 0;

    region(1, 32'h1000, 32'h1FFF, 5'h1F);
    region(2, 32'h1800, 32'h18FF, 5'h03);
    region(3, 32'h4000, 32'h4FFF, 5'h09);
    region(5, 32'h8000, 32'h8FFF, 5'h1E);

    foreach (VEC[i]) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      req_chk(tag, VEC[i].addr, VEC[i].we, VEC[i].prot, VEC[i].pass);
    end
    req_valid = 0;

    // R9 non-secure config writes ignored
    cfg_wr(7, 2'd0, 32'h0, P_NS);
    cfg_wr(7, 2'd1, 32'hFFFF_FFFF, P_NS);
    cfg_wr(7, 2'd2, 32'h1F, P_NS);
    cfg_wr(0, 2'd2, 32'h1E, 3'b111);
    req_chk("R9 ns cfg ignored", 32'h0000_2000, 1'b0, P_NS, 1'b0);
    req_valid = 0;

    // R10 same-cycle config write and request
    cfg_wr(6, 2'd0, 32'h9000, P_S);
    cfg_wr(6, 2'd1, 32'h9FFF, P_S);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(6); cfg_sel = 2'd2; cfg_wdata = 32'h19; cfg_prot = P_S;
    req_valid = 1; req_addr = 32'h9000; req_we = 0; req_prot = P_NS;
    #5;
    check("R10 old setting", {mem_valid, resp_err, resp_rdata}, expect_of(1'b0, 1'b0));
    @(posedge clk); #5;
    check("R10 new setting", {mem_valid, resp_err, resp_rdata}, expect_of(1'b1, 1'b0));
    @(negedge clk);
    cfg_we = 0; req_valid = 0;

    // R11 region 0 perms writable, enable bit ignored
    cfg_wr(0, 2'd2, 32'h08, P_S);
    req_chk("R11 bg ns read", 32'h0000_2000, 1'b0, P_NS, 1'b1);
    req_chk("R11 bg s read", 32'h0000_2000, 1'b0, P_S, 1'b0);
    req_chk("R11 bg ns write", 32'hFFFF_0000, 1'b1, P_NS, 1'b0);
    req_valid = 0;
    @(negedge clk); #5;
    check("R6 idle", {mem_valid, resp_err, resp_rdata}, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule